// File: doc/BRIEF.md
# Threshold Interrupt Reporting Unit

This block watches the stream of finished light-conversion results and decides when to raise an interrupt. Each result, and each of the two limits it is compared with, is a 16-bit word. The upper four bits are an exponent and the lower twelve bits are a mantissa. Comparison is done on the linear value `mantissa << exponent`, so words with different exponents order correctly. A result above the high limit or below the low limit is a fault. A fault only takes effect once the programmed number of consecutive faults in the same direction has been seen.

The unit keeps a flag for each direction, a conversion-ready bit and an internal interrupt state. The interrupt state drives the enable of an open-drain pin, through a polarity select. There are two styles of reporting, picked by a latch select:

- **Latched window:** flags and interrupt hold until the configuration register is read. An alert-response clear drops only the pin.
- **Transparent hysteresis:** flags and pin track the last triggered direction.

When the top two bits of the low limit are both 1, end-of-conversion reporting is on: the interrupt goes active after every result. The strobes for configuration read, configuration write and alert clear come from the register interface, which is outside this block. So does the result source.

Top module: `thresh_irq_unit`

## Requirements
- R1: Words are split as exponent = bits 15:12 and mantissa = bits 11:0, with linear value mantissa × 2^exponent. A result is above-high when its linear value is greater than the high limit's, and below-low when it is less than the low limit's. Equality is not a fault. When both hold, above-high wins.
- R2: The fault-count code 0, 1, 2, 3 needs 1, 2, 4, 8 consecutive same-direction faults before a trigger fires. Each further same-direction fault also triggers. An in-window result, or a change of direction, restarts the count.
- R3: With latch_i = 1, an above-high trigger sets flag_hi_o and activates the interrupt. A below-low trigger sets flag_lo_o and activates the interrupt. Both flags hold until cleared.
- R4: With latch_i = 1, cfg_rd_i clears both flags and the interrupt. alert_clr_i clears only the interrupt.
- R5: With latch_i = 0:
  - an above-high trigger gives flag_hi_o = 1, flag_lo_o = 0 and an active interrupt;
  - a below-low trigger gives flag_hi_o = 0, flag_lo_o = 1 and an inactive interrupt;
  - reads, writes and alert clears change neither flags nor interrupt.
- R6: When lo_lim_i[15:14] = 11, every result makes the interrupt active. With latch_i = 1 it is cleared by a read, by a write whose mode is non-zero, or by an alert clear. With latch_i = 0 it is cleared only by a read or a non-zero-mode write.
- R7: conv_rdy_o is set by every result. It is cleared by cfg_rd_i, or by cfg_wr_i with cfg_wr_mode_i ≠ 00. A write with mode 00 leaves it unchanged.
- R8: pin_pull_o (1 = drive the pin low) equals the interrupt state when pol_i = 0, and its inverse when pol_i = 1.
- R9: After reset, both flags and conv_rdy_o are 0 and the interrupt is inactive.
- R10: All state updates at the clock edge that samples the strobes. When a result arrives in the same cycle as a clearing strobe, the setting effect of the result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | A conversion result is complete this cycle |
| res_i | input | 16 | Result word (exponent, mantissa) |
| lo_lim_i | input | 16 | Low limit word; bits 15:14 = 11 selects end-of-conversion reporting |
| hi_lim_i | input | 16 | High limit word |
| latch_i | input | 1 | 1 = latched window, 0 = transparent hysteresis |
| pol_i | input | 1 | Pin polarity: 0 active low, 1 active high |
| fc_i | input | 2 | Fault-count code |
| cfg_rd_i | input | 1 | Configuration register read strobe |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_wr_mode_i | input | 2 | Conversion mode in the written configuration |
| alert_clr_i | input | 1 | Alert-response clear strobe |
| flag_hi_o | output | 1 | Above-high flag |
| flag_lo_o | output | 1 | Below-low flag |
| conv_rdy_o | output | 1 | Conversion-ready bit |
| pin_pull_o | output | 1 | Enable of the open-drain pull-down |

## Verification
The properties take for granted that the high limit is not below the low limit. Only under that ordering do the two flags behave as in R3 and R5. They also assume that fc_i changes only while the fault count is zero, and that strobes last one cycle each.

The stimulus holds the limits in order, except in the comparison sweep, where both limits share one value. It changes fc_i only after an in-window result, and it releases every strobe at the next falling edge. A cycle-level model in the bench, derived from the requirements, predicts all four outputs after each step. That model covers every combination of reporting style, end-of-conversion setting and polarity.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_HI   = 2'd1,
    DIR_LO   = 2'd2
  } fault_dir_e;
endpackage

// File: rtl/thr_lin_cmp.sv
module thr_lin_cmp #(
  parameter int EXP_W  = 4,
  parameter int MANT_W = 12
) (
  input  logic [EXP_W+MANT_W-1:0] a_i,
  input  logic [EXP_W+MANT_W-1:0] b_i,
  output logic                    gt_o,
  output logic                    lt_o
);
  localparam int VAL_W = EXP_W + MANT_W;
  localparam int LIN_W = MANT_W + (1 << EXP_W) - 1;

  logic [LIN_W-1:0] a_lin, b_lin;

  always_comb begin
    a_lin = LIN_W'(a_i[MANT_W-1:0]) << a_i[VAL_W-1 -: EXP_W];
    b_lin = LIN_W'(b_i[MANT_W-1:0]) << b_i[VAL_W-1 -: EXP_W];
    gt_o  = a_lin > b_lin;
    lt_o  = a_lin < b_lin;
  end
endmodule

// File: rtl/thr_fault_gate.sv
module thr_fault_gate
  import thr_pkg::*;
#(
  parameter int FC_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            above_i,
  input  logic            below_i,
  input  logic [FC_W-1:0] fc_i,
  output logic            trig_hi_o,
  output logic            trig_lo_o
);
  localparam int MAX_NEED = 1 << ((1 << FC_W) - 1);
  localparam int CNT_W    = $clog2(MAX_NEED + 1);

  fault_dir_e       dir_q, dir_now;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, need;

  always_comb begin
    need    = CNT_W'(1) << fc_i;
    dir_now = above_i ? DIR_HI : (below_i ? DIR_LO : DIR_NONE);
    if (dir_now == DIR_NONE)
      cnt_nxt = '0;
    else if (dir_now == dir_q)
      cnt_nxt = (cnt_q == CNT_W'(MAX_NEED)) ? cnt_q : cnt_q + CNT_W'(1);
    else
      cnt_nxt = CNT_W'(1);
    trig_hi_o = valid_i && (dir_now == DIR_HI) && (cnt_nxt >= need);
    trig_lo_o = valid_i && (dir_now == DIR_LO) && (cnt_nxt >= need);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_NONE;
    end else if (valid_i) begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_now;
    end
  end
endmodule

// File: rtl/thresh_irq_unit.sv
module thresh_irq_unit #(
  parameter int EXP_W  = 4,
  parameter int MANT_W = 12,
  parameter int FC_W   = 2,
  parameter int MODE_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res_valid_i,
  input  logic [EXP_W+MANT_W-1:0] res_i,
  input  logic [EXP_W+MANT_W-1:0] lo_lim_i,
  input  logic [EXP_W+MANT_W-1:0] hi_lim_i,
  input  logic                    latch_i,
  input  logic                    pol_i,
  input  logic [FC_W-1:0]         fc_i,
  input  logic                    cfg_rd_i,
  input  logic                    cfg_wr_i,
  input  logic [MODE_W-1:0]       cfg_wr_mode_i,
  input  logic                    alert_clr_i,
  output logic                    flag_hi_o,
  output logic                    flag_lo_o,
  output logic                    conv_rdy_o,
  output logic                    pin_pull_o
);
  localparam int VAL_W = EXP_W + MANT_W;

  logic above_hi, below_lo, unused_gt_lo, unused_lt_hi;
  logic trig_hi, trig_lo;
  logic eoc, wr_run;
  logic flag_hi_q, flag_lo_q, rdy_q, irq_q;
  logic flag_hi_d, flag_lo_d, rdy_d, irq_d;

  thr_lin_cmp #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_cmp_hi (
    .a_i(res_i), .b_i(hi_lim_i), .gt_o(above_hi), .lt_o(unused_lt_hi)
  );
  thr_lin_cmp #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_cmp_lo (
    .a_i(res_i), .b_i(lo_lim_i), .gt_o(unused_gt_lo), .lt_o(below_lo)
  );

  // above-high takes precedence if the limits are inverted
  thr_fault_gate #(.FC_W(FC_W)) i_fault_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (res_valid_i),
    .above_i   (above_hi),
    .below_i   (below_lo && !above_hi),
    .fc_i      (fc_i),
    .trig_hi_o (trig_hi),
    .trig_lo_o (trig_lo)
  );

  assign eoc    = lo_lim_i[VAL_W-1 -: 2] == 2'b11;
  assign wr_run = cfg_wr_i && (cfg_wr_mode_i != '0);

  always_comb begin
    flag_hi_d = flag_hi_q;
    flag_lo_d = flag_lo_q;
    irq_d     = irq_q;
    rdy_d     = rdy_q;
    if (cfg_rd_i || wr_run) rdy_d = 1'b0;
    if (latch_i) begin
      if (cfg_rd_i) begin
        flag_hi_d = 1'b0;
        flag_lo_d = 1'b0;
        irq_d     = 1'b0;
      end
      if (alert_clr_i)   irq_d = 1'b0;
      if (eoc && wr_run) irq_d = 1'b0;
      if (trig_hi) begin
        flag_hi_d = 1'b1;
        irq_d     = 1'b1;
      end
      if (trig_lo) begin
        flag_lo_d = 1'b1;
        irq_d     = 1'b1;
      end
    end else begin
      if (eoc && (cfg_rd_i || wr_run)) irq_d = 1'b0;
      if (trig_hi) begin
        flag_hi_d = 1'b1;
        flag_lo_d = 1'b0;
        irq_d     = 1'b1;
      end
      if (trig_lo) begin
        flag_hi_d = 1'b0;
        flag_lo_d = 1'b1;
        irq_d     = 1'b0;
      end
    end
    // setting effects of a result override same-cycle clears
    if (res_valid_i) begin
      rdy_d = 1'b1;
      if (eoc) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_hi_q <= 1'b0;
      flag_lo_q <= 1'b0;
      rdy_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      flag_hi_q <= flag_hi_d;
      flag_lo_q <= flag_lo_d;
      rdy_q     <= rdy_d;
      irq_q     <= irq_d;
    end
  end

  assign flag_hi_o  = flag_hi_q;
  assign flag_lo_o  = flag_lo_q;
  assign conv_rdy_o = rdy_q;
  assign pin_pull_o = irq_q ^ pol_i;
endmodule

// File: rtl/thr_irq_chk.sv
module thr_irq_chk #(
  parameter int VAL_W  = 16,
  parameter int FC_W   = 2,
  parameter int MODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic [VAL_W-1:0]  lo_lim_i,
  input logic              latch_i,
  input logic [FC_W-1:0]   fc_i,
  input logic              cfg_rd_i,
  input logic              cfg_wr_i,
  input logic [MODE_W-1:0] cfg_wr_mode_i,
  input logic              alert_clr_i,
  input logic              above_hi,
  input logic              irq_q,
  input logic              flag_hi_o,
  input logic              flag_lo_o,
  input logic              conv_rdy_o
);
  AST_LATCH_SINGLE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && fc_i == '0 && res_valid_i && above_hi |=> flag_hi_o); // R3

  AST_LATCH_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && cfg_rd_i && !res_valid_i |=> !flag_hi_o && !flag_lo_o && !irq_q); // R4

  AST_LATCH_ALERT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && alert_clr_i && !res_valid_i |=> !irq_q); // R4

  AST_XPR_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i && !res_valid_i |=> $stable(flag_hi_o) && $stable(flag_lo_o)); // R5

  AST_EOC_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_lim_i[VAL_W-1 -: 2] == 2'b11 && res_valid_i |=> irq_q); // R6

  AST_RDY_ON_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> conv_rdy_o); // R7

  AST_RDY_SHUTDOWN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && cfg_wr_mode_i == '0 && !cfg_rd_i && !res_valid_i |=> $stable(conv_rdy_o)); // R7
endmodule

bind thresh_irq_unit thr_irq_chk #(
  .VAL_W(EXP_W + MANT_W), .FC_W(FC_W), .MODE_W(MODE_W)
) i_thr_irq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .res_valid_i  (res_valid_i),
  .lo_lim_i     (lo_lim_i),
  .latch_i      (latch_i),
  .fc_i         (fc_i),
  .cfg_rd_i     (cfg_rd_i),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_wr_mode_i(cfg_wr_mode_i),
  .alert_clr_i  (alert_clr_i),
  .above_hi     (above_hi),
  .irq_q        (irq_q),
  .flag_hi_o    (flag_hi_o),
  .flag_lo_o    (flag_lo_o),
  .conv_rdy_o   (conv_rdy_o)
);

// File: tb/test_thresh_irq_unit.sv
module test_thresh_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic res_valid = 1'b0;
  logic [15:0] res = '0, lo_lim = 16'h1100, hi_lim = 16'h2400;
  logic latch = 1'b1, pol = 1'b0;
  logic [1:0] fc = '0, mode = '0;
  logic cfg_rd = 1'b0, cfg_wr = 1'b0, alert = 1'b0;
  logic flag_hi, flag_lo, conv_rdy, pin_pull;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_fh, m_fl, m_rdy, m_irq;
  int m_cnt, m_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  thresh_irq_unit i_thresh_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .res_valid_i(res_valid), .res_i(res),
    .lo_lim_i(lo_lim), .hi_lim_i(hi_lim), .latch_i(latch), .pol_i(pol),
    .fc_i(fc), .cfg_rd_i(cfg_rd), .cfg_wr_i(cfg_wr), .cfg_wr_mode_i(mode),
    .alert_clr_i(alert), .flag_hi_o(flag_hi), .flag_lo_o(flag_lo),
    .conv_rdy_o(conv_rdy), .pin_pull_o(pin_pull)
  );

  function automatic longint lin(input logic [15:0] w);
    return longint'(w[11:0]) << w[15:12];
  endfunction

  task automatic compare(input string tag);
    bit e_pin;
    e_pin = pol ? !m_irq : m_irq;
    n_chk++;
    if (flag_hi !== m_fh || flag_lo !== m_fl || conv_rdy !== m_rdy || pin_pull !== e_pin) begin
      n_fail++;
      $display("FAIL %s: got fh=%b fl=%b rdy=%b pin=%b, expected fh=%b fl=%b rdy=%b pin=%b",
               tag, flag_hi, flag_lo, conv_rdy, pin_pull, m_fh, m_fl, m_rdy, e_pin);
    end
  endtask

  // model derived from R1..R10, evaluated at the sampling edge
  task automatic model(input bit v, input logic [15:0] r, input bit rd, input bit wr,
                       input logic [1:0] md, input bit al);
    int d, need;
    bit th, tl, eoc, run;
    th = 0; tl = 0;
    need = 1 << fc;
    eoc = lo_lim[15:14] == 2'b11;
    run = wr && md != 2'b00;
    if (v) begin
      d = lin(r) > lin(hi_lim) ? 1 : (lin(r) < lin(lo_lim) ? 2 : 0);
      if (d == 0) m_cnt = 0;
      else if (d == m_dir) m_cnt = (m_cnt < 8) ? m_cnt + 1 : 8;
      else m_cnt = 1;
      m_dir = d;
      th = d == 1 && m_cnt >= need;
      tl = d == 2 && m_cnt >= need;
    end
    if (rd || run) m_rdy = 0;
    if (latch) begin
      if (rd) begin m_fh = 0; m_fl = 0; m_irq = 0; end
      if (al) m_irq = 0;
      if (eoc && run) m_irq = 0;
      if (th) begin m_fh = 1; m_irq = 1; end
      if (tl) begin m_fl = 1; m_irq = 1; end
    end else begin
      if (eoc && (rd || run)) m_irq = 0;
      if (th) begin m_fh = 1; m_fl = 0; m_irq = 1; end
      if (tl) begin m_fh = 0; m_fl = 1; m_irq = 0; end
    end
    if (v) begin
      m_rdy = 1;
      if (eoc) m_irq = 1;
    end
  endtask

  task automatic step(input bit v, input logic [15:0] r, input bit rd, input bit wr,
                      input logic [1:0] md, input bit al, input string tag);
    res_valid = v; res = r; cfg_rd = rd; cfg_wr = wr; mode = md; alert = al;
    @(posedge clk);
    model(v, r, rd, wr, md, al);
    @(negedge clk);
    res_valid = 0; cfg_rd = 0; cfg_wr = 0; alert = 0;
    compare(tag);
  endtask

  task automatic put(input logic [15:0] r, input string tag);
    step(1, r, 0, 0, 2'b00, 0, tag);
  endtask

  localparam logic [15:0] ABOVE  = 16'h3300; // 0x1800 linear
  localparam logic [15:0] BELOW  = 16'h0100; // 0x100 linear
  localparam logic [15:0] INSIDE = 16'h0800; // 0x800 linear

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lims [4];
    logic [11:0] mants [6];
    lims[0] = 16'h0FFF; lims[1] = 16'h5123; lims[2] = 16'hB800; lims[3] = 16'h3001;
    m_fh = 0; m_fl = 0; m_rdy = 0; m_irq = 0; m_cnt = 0; m_dir = 0;

    // R9 reset state, R8 polarity at reset
    #(CLK_PERIOD * 3);
    compare("R9 reset pol0");
    pol = 1; #1;
    compare("R9 R8 reset pol1");
    pol = 0;
    @(negedge clk); rst_ni = 1;
    @(negedge clk);

    // R1 linear comparison sweep, transparent, single fault
    latch = 0; fc = 0;
    foreach (lims[li]) begin
      lo_lim = lims[li]; hi_lim = lims[li];
      mants[0] = 12'h000; mants[1] = 12'h001; mants[2] = 12'h400;
      mants[3] = 12'h800; mants[4] = 12'hFFF; mants[5] = lims[li][11:0];
      for (int e = 0; e < 16; e++)
        foreach (mants[mi]) put({e[3:0], mants[mi]}, "R1 linear compare");
      put(lims[li], "R1 equal is no fault");
    end
    lo_lim = 16'h1100; hi_lim = 16'h2400;
    put(INSIDE, "R1 in window");

    // R2 fault counting, latched
    latch = 1;
    for (int f = 0; f < 4; f++) begin
      fc = f[1:0];
      step(0, '0, 1, 0, 2'b00, 0, "R4 clear before count");
      for (int k = 1; k < (1 << f); k++) put(ABOVE, "R2 below count high");
      put(INSIDE, "R2 window restarts");
      for (int k = 1; k <= (1 << f); k++) put(ABOVE, "R2 count reached high");
      put(INSIDE, "R2 window");
      step(0, '0, 1, 0, 2'b00, 0, "R4 read");
      for (int k = 1; k <= (1 << f); k++) put(BELOW, "R2 count reached low");
      put(INSIDE, "R2 window");
    end
    fc = 2;
    step(0, '0, 1, 0, 2'b00, 0, "R4 read");
    for (int k = 0; k < 3; k++) put(ABOVE, "R2 direction run");
    put(BELOW, "R2 direction change");
    for (int k = 0; k < 3; k++) put(ABOVE, "R2 restarted run");
    put(ABOVE, "R2 fourth fault triggers");
    put(INSIDE, "R2 window");

    // R3 / R4 latched
    fc = 0;
    step(0, '0, 1, 0, 2'b00, 0, "R4 read");
    put(ABOVE, "R3 latched high");
    put(INSIDE, "R3 flag holds");
    put(BELOW, "R3 latched low with high held");
    step(0, '0, 0, 0, 2'b00, 1, "R4 alert clears pin only");
    step(0, '0, 0, 1, 2'b01, 0, "R4 write leaves flags");
    step(0, '0, 1, 0, 2'b00, 0, "R4 read clears all");

    // R5 transparent
    latch = 0;
    put(ABOVE, "R5 high active");
    step(0, '0, 1, 0, 2'b00, 0, "R5 read ignored");
    step(0, '0, 0, 1, 2'b10, 0, "R5 write ignored");
    step(0, '0, 0, 0, 2'b00, 1, "R5 alert ignored");
    put(BELOW, "R5 low inactive");
    put(INSIDE, "R5 window holds");
    step(0, '0, 1, 0, 2'b00, 0, "R5 read ignored");

    // R6 end-of-conversion
    lo_lim = 16'hC000;
    latch = 1;
    step(0, '0, 1, 0, 2'b00, 0, "R6 read");
    put(INSIDE, "R6 latched eoc active");
    step(0, '0, 1, 0, 2'b00, 0, "R6 read clears");
    put(INSIDE, "R6 eoc again");
    step(0, '0, 0, 1, 2'b00, 0, "R6 shutdown write keeps");
    step(0, '0, 0, 1, 2'b11, 0, "R6 run write clears");
    put(INSIDE, "R6 eoc again");
    step(0, '0, 0, 0, 2'b00, 1, "R6 alert clears latched");
    latch = 0;
    put(INSIDE, "R6 transparent eoc active");
    step(0, '0, 0, 0, 2'b00, 1, "R6 alert ignored transparent");
    step(0, '0, 0, 1, 2'b01, 0, "R6 run write clears transparent");
    put(ABOVE, "R6 eoc with high trigger");
    step(0, '0, 1, 0, 2'b00, 0, "R6 read clears transparent");
    lo_lim = 16'h1100;

    // R7 conversion ready
    put(INSIDE, "R7 set");
    step(0, '0, 0, 1, 2'b00, 0, "R7 mode 00 write keeps");
    step(0, '0, 0, 1, 2'b10, 0, "R7 run write clears");
    put(INSIDE, "R7 set");
    step(0, '0, 1, 0, 2'b00, 0, "R7 read clears");

    // R8 polarity with interrupt both ways
    latch = 1;
    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      step(0, '0, 1, 0, 2'b00, 0, "R8 inactive");
      put(ABOVE, "R8 active");
    end
    pol = 0;

    // R10 set wins over same-cycle clear
    step(0, '0, 1, 0, 2'b00, 0, "R4 read");
    step(1, ABOVE, 1, 0, 2'b00, 1, "R10 result beats read and alert");
    step(1, INSIDE, 0, 1, 2'b01, 0, "R10 result beats run write");
    lo_lim = 16'hC000;
    step(1, INSIDE, 1, 0, 2'b00, 1, "R10 eoc beats clears");
    lo_lim = 16'h1100;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule